// File: doc/BRIEF.md
# Burst Beat Address and Lane Walker

This block takes one burst request (start address, length field, size field and burst kind) through a valid/ready handshake. It then walks the burst one beat at a time. For each beat it presents the address, the byte-lane enable mask for a data bus `DATA_BYTES` wide, and a flag that marks the final beat. The consumer pulses `beat_adv` for each beat it takes. It may hold the pulse low for as long as it needs, and the current beat stays on the outputs until it is consumed.

It handles fixed-address, incrementing and wrapping bursts. It also handles narrow beats, where the beat is smaller than the bus, and a first beat that is not aligned to the beat size. A request that cannot be carried out is refused. The refusal is a one-cycle error pulse, and no beats are produced.

Top module: `burst_beat_walker`

## Requirements
- R1: `req_ready` is high exactly when no burst is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its first beat shows on `beat_valid` in the next cycle.
- R2: `req_kind` codes are 2'b00 fixed, 2'b01 incrementing, 2'b10 wrapping and 2'b11 reserved. A beat carries 2^`req_size` bytes, and a burst has `req_len`+1 beats.
- R3: The first beat address equals the start address as given, aligned or not.
- R4: In an incrementing burst, each later beat address equals the previous address rounded down to a multiple of the beat bytes, plus the beat bytes.
- R5: In a fixed burst, every beat has the start address and the same lane mask.
- R6: In a wrapping burst the span is beat bytes times beat count, and the lower bound is the start rounded down to a multiple of the span. A step that would reach the lower bound plus the span goes back to the lower bound instead.
- R7: The lane mask enables lane i (bit i, lane 0 = bus byte 0) when i is at or above the address modulo `DATA_BYTES` and below the end of the beat-size container that holds the address. An unaligned first beat therefore enables only the upper part of its container.
- R8: In a narrow burst, the enabled lanes follow the address modulo `DATA_BYTES`, so successive beats move across the bus.
- R9: `beat_last` is high only on the final beat, a burst presents exactly `req_len`+1 beats, and a beat stays unchanged while `beat_adv` is low.
- R10: A request is illegal when its kind is reserved, when 2^`req_size` exceeds `DATA_BYTES`, or when it is a wrapping burst whose beat count is not 2, 4, 8 or 16 or whose start is not aligned to the beat bytes. An illegal request raises `req_err` for exactly the cycle after acceptance and produces no beats.
- R11: After reset, `beat_valid`, `beat_last` and `req_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start address |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_kind | input | 2 | Burst kind code |
| req_err | output | 1 | One-cycle pulse for a refused request |
| beat_valid | output | 1 | A beat is presented |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_strb | output | DATA_BYTES | Byte-lane enables of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| beat_adv | input | 1 | Consumer takes the current beat |

## Verification
Some properties are checked by assertions on every cycle. These are:
- a refused request never coexists with a beat;
- the final consumed beat ends the burst;
- fixed bursts hold their address;
- post-first beats of moving bursts are aligned;
- wrapping addresses stay inside their span;
- a presented beat never has an empty lane mask.

The exact sequence of addresses and masks is shown only by the bench scenarios. The bench compares every beat against a reference walk, which covers the wrap-back point, the unaligned first beat, narrow lane rotation, a 256-beat burst and each illegal case.

// File: rtl/burst_beat_walker.sv
module burst_beat_walker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [7:0]            req_len,
  input  logic [2:0]            req_size,
  input  logic [1:0]            req_kind,
  output logic                  req_err,
  output logic                  beat_valid,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [DATA_BYTES-1:0] beat_strb,
  output logic                  beat_last,
  input  logic                  beat_adv
);
  localparam int LANE_W = $clog2(DATA_BYTES);
  localparam logic [1:0] K_FIXED = 2'b00;
  localparam logic [1:0] K_INCR  = 2'b01;
  localparam logic [1:0] K_WRAP  = 2'b10;
  localparam logic [1:0] K_RSVD  = 2'b11;

  logic              busy, err_q;
  logic [ADDR_W-1:0] cur, wlo, wspan;
  logic [7:0]        left;
  logic [2:0]        sz;
  logic [1:0]        kind;

  wire [ADDR_W-1:0] rnb    = ADDR_W'(1) << req_size;
  wire [ADDR_W-1:0] rspan  = rnb * (ADDR_W'(req_len) + ADDR_W'(1));
  wire              len_ok = (req_len == 8'd1) || (req_len == 8'd3) ||
                             (req_len == 8'd7) || (req_len == 8'd15);
  wire              al_ok  = (req_addr & (rnb - ADDR_W'(1))) == '0;
  wire              bad    = (req_kind == K_RSVD) || (32'(req_size) > LANE_W) ||
                             ((req_kind == K_WRAP) && !(len_ok && al_ok));
  wire              take   = req_valid && req_ready;

  wire [ADDR_W-1:0] nb     = ADDR_W'(1) << sz;
  wire [ADDR_W-1:0] cur_al = cur & ~(nb - ADDR_W'(1));
  wire [ADDR_W-1:0] step   = cur_al + nb;
  wire [ADDR_W-1:0] nxt    = (kind == K_FIXED) ? cur :
                             ((kind == K_WRAP) && (step == wlo + wspan)) ? wlo : step;

  assign req_ready  = !busy;
  assign req_err    = err_q;
  assign beat_valid = busy;
  assign beat_addr  = cur;
  assign beat_last  = busy && (left == 8'd0);

  always_comb begin
    for (int i = 0; i < DATA_BYTES; i++)
      beat_strb[i] = busy && (i >= int'(cur[LANE_W-1:0])) &&
                     (i < int'(cur_al[LANE_W-1:0]) + int'(nb));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      err_q <= 1'b0;
      cur   <= '0;
      wlo   <= '0;
      wspan <= '0;
      left  <= '0;
      sz    <= '0;
      kind  <= K_FIXED;
    end else begin
      err_q <= 1'b0;
      if (take) begin
        if (bad) err_q <= 1'b1;
        else begin
          busy  <= 1'b1;
          cur   <= req_addr;
          wspan <= rspan;
          wlo   <= req_addr & ~(rspan - ADDR_W'(1));
          left  <= req_len;
          sz    <= req_size;
          kind  <= req_kind;
        end
      end else if (busy && beat_adv) begin
        if (left == 8'd0) busy <= 1'b0;
        else begin
          cur  <= nxt;
          left <= left - 8'd1;
        end
      end
    end
  end

  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !beat_valid); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready); // R1
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_last && beat_adv |=> !beat_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_adv |=> beat_valid && $stable(beat_addr) && $stable(beat_strb)); // R9
  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last && kind == K_FIXED |=> $stable(beat_addr)); // R5
  AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_adv && !beat_last && kind != K_FIXED |=>
    (beat_addr & (nb - ADDR_W'(1))) == '0); // R4
  AST_WRAP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && kind == K_WRAP |-> beat_addr >= wlo && beat_addr < wlo + wspan); // R6
  AST_STRB_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_strb != '0); // R7
endmodule

// File: tb/sim_burst_beat_walker.sv
module sim_burst_beat_walker;
  localparam int DB = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, beat_adv = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic [2:0] req_size = '0;
  logic [1:0] req_kind = '0;
  logic req_ready, req_err, beat_valid, beat_last;
  logic [31:0] beat_addr;
  logic [DB-1:0] beat_strb;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  burst_beat_walker #(.ADDR_W(32), .DATA_BYTES(DB)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_len, .req_size,
    .req_kind, .req_err, .beat_valid, .beat_addr, .beat_strb, .beat_last, .beat_adv);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_addr(logic [31:0] st, int sz, int len, int kind, int k);
    logic [31:0] nb = 32'(1) << sz;
    logic [31:0] span = nb * 32'(len + 1);
    logic [31:0] lo = (st / span) * span;
    logic [31:0] a = st;
    for (int j = 0; j < k; j++) begin
      if (kind != 0) begin
        a = (a / nb) * nb + nb;
        if (kind == 2 && a == lo + span) a = lo;
      end
    end
    return a;
  endfunction

  function automatic logic [DB-1:0] f_strb(logic [31:0] a, int sz);
    logic [31:0] nb = 32'(1) << sz;
    int lo = int'(a % DB);
    int base = int'(((a / nb) * nb) % DB);
    logic [DB-1:0] s;
    for (int i = 0; i < DB; i++) s[i] = (i >= lo) && (i < base + int'(nb));
    return s;
  endfunction

  function automatic bit f_legal(logic [31:0] st, int sz, int len, int kind);
    if (kind == 3) return 1'b0;
    if ((1 << sz) > DB) return 1'b0;
    if (kind == 2 && !(len == 1 || len == 3 || len == 7 || len == 15)) return 1'b0;
    if (kind == 2 && (st % (32'(1) << sz)) != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic burst(input logic [31:0] st, input int sz, input int len, input int kind, input bit stalls);
    logic [31:0] ea;
    string tg;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    req_valid = 1'b1; req_addr = st; req_len = 8'(len); req_size = 3'(sz); req_kind = 2'(kind);
    @(negedge clk);
    req_valid = 1'b0;
    if (!f_legal(st, sz, len, kind)) begin
      chk(req_err == 1'b1 && beat_valid == 1'b0, "R10", {req_err, beat_valid}, 2'b10);
      @(negedge clk);
      chk(req_err == 1'b0 && beat_valid == 1'b0 && req_ready == 1'b1, "R10",
          {req_err, beat_valid, req_ready}, 3'b001);
      return;
    end
    chk(req_err == 1'b0 && req_ready == 1'b0, "R1", {req_err, req_ready}, 2'b00);
    for (int k = 0; k <= len; k++) begin
      ea = f_addr(st, sz, len, kind, k);
      tg = (k == 0) ? "R3" : (kind == 0) ? "R5" : (kind == 1) ? "R4" : "R6";
      if (stalls && ($urandom % 4 == 0)) begin
        @(negedge clk);
        chk(beat_valid && beat_addr == ea, "R9", beat_addr, ea);
      end
      chk(beat_valid == 1'b1, "R9", beat_valid, 1);
      chk(beat_addr == ea, tg, beat_addr, ea);
      chk(beat_strb == f_strb(ea, sz), (sz < 2) ? "R8" : "R7", beat_strb, f_strb(ea, sz));
      chk(beat_last == (k == len), "R9", beat_last, (k == len));
      beat_adv = 1'b1;
      @(negedge clk);
      beat_adv = 1'b0;
    end
    chk(beat_valid == 1'b0 && req_ready == 1'b1, "R9", {beat_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int kd, sz, ln;
    logic [31:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(beat_valid == 0 && beat_last == 0 && req_err == 0 && req_ready == 1, "R11",
        {beat_valid, beat_last, req_err, req_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(beat_valid == 0 && req_ready == 1, "R11", {beat_valid, req_ready}, 2'b01);
    burst(32'h23, 2, 7, 1, 1'b0);     // R7 unaligned first beat, R2 incr code
    burst(32'h01, 0, 5, 1, 1'b0);     // R8 narrow byte beats
    burst(32'h06, 1, 4, 1, 1'b1);     // R8 halfword beats
    burst(32'h34, 2, 3, 2, 1'b0);     // R6 wrap back to 0x30
    burst(32'h1e, 1, 7, 2, 1'b1);     // R6 narrow wrap
    burst(32'h22, 1, 3, 0, 1'b1);     // R5 fixed narrow
    burst(32'h1001, 2, 2, 0, 1'b0);   // R5 fixed unaligned
    burst(32'h0, 2, 255, 1, 1'b0);    // R2 longest incr
    burst(32'h40, 2, 0, 1, 1'b0);     // R9 single beat
    burst(32'h40, 2, 3, 3, 1'b0);     // R10 reserved kind
    burst(32'h40, 2, 2, 2, 1'b0);     // R10 wrap of 3 beats
    burst(32'h22, 2, 3, 2, 1'b0);     // R10 unaligned wrap
    burst(32'h40, 3, 1, 1, 1'b0);     // R10 beat wider than bus
    for (int n = 0; n < 80; n++) begin
      kd = int'($urandom % 3);
      sz = int'($urandom % 3);
      a  = $urandom & 32'hffff;
      if (kd == 2) begin
        ln = (2 << ($urandom % 4)) - 1;
        a = a & ~((32'(1) << sz) - 1);
      end else ln = int'($urandom % 17);
      if ($urandom % 10 == 0) kd = 3;
      burst(a, sz, ln, kd, 1'b1);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule